// File: doc/BRIEF.md
# GPIO Event Detector and Interrupt

This block watches a word of GPIO input levels (already resolved and polarity-adjusted upstream) and turns activity on each pin into a sticky status bit. Each pin has its own trigger mode. It can fire while the pin is high, on a rising edge, or on any change. Edges are found by comparing the present input word with a copy registered on the previous clock.

Software programs the trigger modes and an interrupt enable mask through a small word-addressed register port. The enable mask has separate set and clear aliases, so single bits can be changed without a read-modify-write. Status bits are cleared by writing ones. One level-sensitive interrupt line is raised while any enabled status bit is set.

A pin in high-level mode whose input is still high cannot be cleared: the trigger in that cycle takes priority over the clear, so the bit stays set.

Top module: `gpio_evt_irq`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0 and `irq` is low. The edge reference is loaded from `in_word` during reset, so levels present at reset release produce no edge.
- R2: A pin whose mode bit is 0 is in high-level mode. Its status bit is set on every clock edge at which its input bit is 1.
- R3: A pin whose mode bit is 1 and whose both-edge bit is 1 sets its status bit on any clock where its input differs from the previous clock's input.
- R4: A pin whose mode bit is 1 and whose both-edge bit is 0 sets its status bit only on a 0-to-1 change. A 1-to-0 change has no effect on status.
- R5: Status bits are sticky. Writing 0 to a status bit leaves it unchanged, and a status bit never sets without a trigger.
- R6: Writing 1 to a status bit clears it on that clock edge when no trigger for that bit occurs in the same cycle.
- R7: When a status clear and a trigger on the same bit fall in the same cycle, the trigger wins and the bit stays set.
- R8: A write to the enable-set alias ORs the written word into the enable mask. A write to the enable-clear alias removes the written ones from it. Both aliases read as 0 and touch no other register.
- R9: `irq` is registered. After each clock edge it equals the OR of (status AND enable), taken from the values loaded at that same edge.
- R10: The register word offsets are as follows: mode at 0x00, both-edge select at 0x04, enable at 0x08, enable-set at 0x0C, enable-clear at 0x10, status at 0x14. Reads of any other offset, and of misaligned addresses, return 0. Writes to them change nothing.
- R11: Trigger evaluation uses the configuration registers as they stood before the current clock edge. A configuration write therefore affects status from the following edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data for `bus_addr`, combinational |
| in_word | input | PINS | Polarity-adjusted input levels, one bit per pin |
| irq | output | 1 | Level interrupt, high while any enabled status bit is set |

## Verification
Two functions can fall in the same cycle. The first is a write-one-to-clear of a status bit. The second is a fresh trigger on that same bit, either from a level-mode pin held high or from an edge arriving on the write's clock.

The bench provokes this in two ways. Directed cycles issue the clear while the pin stays high, and again while an edge is driven on that same clock. A pseudo-random phase then mixes status clears, alias writes and input toggles freely. In every cycle the bench's behavioural model decides whether the bit stays set (the trigger wins) or drops. It compares both the status read-back and `irq` after that edge.

// File: rtl/gpio_evt_pkg.sv
// Package: register word indices and trigger-mode decode shared by the
// event detector modules. Assumes word-aligned 32-bit-style register slots.
package gpio_evt_pkg;

    localparam int unsigned REG_MODE   = 0;
    localparam int unsigned REG_BOTH   = 1;
    localparam int unsigned REG_EN     = 2;
    localparam int unsigned REG_EN_SET = 3;
    localparam int unsigned REG_EN_CLR = 4;
    localparam int unsigned REG_STAT   = 5;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_ANY   = 2'd2
    } trig_e;

    // Map a pin's mode and both-edge bits onto its trigger kind.
    function automatic trig_e pick_trig(input logic mode_b, input logic both_b);
        if (!mode_b)
            return TRIG_LEVEL;
        else if (both_b)
            return TRIG_ANY;
        else
            return TRIG_RISE;
    endfunction

endpackage

// File: rtl/evt_cfg_regs.sv
// Module: evt_cfg_regs
// Holds the mode, both-edge and enable registers, decodes the register
// port and forms the read mux and the status clear vector.
// Assumes: byte addresses, word slots; low two address bits must be zero.
module evt_cfg_regs
    import gpio_evt_pkg::*;
#(
    parameter int unsigned PINS   = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    input  logic [PINS-1:0]   stat_q,
    output logic [PINS-1:0]   mode_q,
    output logic [PINS-1:0]   both_q,
    output logic [PINS-1:0]   en_q,
    output logic [PINS-1:0]   en_nxt,
    output logic [PINS-1:0]   clr_vec,
    output logic [PINS-1:0]   bus_rdata
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             sel_mode, sel_both, sel_en, sel_set, sel_clr, sel_stat;

    // Split the address into word index and alignment check.
    always_comb begin
        idx     = bus_addr[ADDR_W-1:2];
        aligned = (bus_addr[1:0] == 2'b00);
    end

    // Decode one select per register slot.
    always_comb begin
        sel_mode = aligned && (idx == IDX_W'(REG_MODE));
        sel_both = aligned && (idx == IDX_W'(REG_BOTH));
        sel_en   = aligned && (idx == IDX_W'(REG_EN));
        sel_set  = aligned && (idx == IDX_W'(REG_EN_SET));
        sel_clr  = aligned && (idx == IDX_W'(REG_EN_CLR));
        sel_stat = aligned && (idx == IDX_W'(REG_STAT));
    end

    // Next enable mask from direct, set-alias and clear-alias writes.
    always_comb begin
        en_nxt = en_q;
        if (bus_wr) begin
            if (sel_en)
                en_nxt = bus_wdata;
            else if (sel_set)
                en_nxt = en_q | bus_wdata;
            else if (sel_clr)
                en_nxt = en_q & ~bus_wdata;
        end
    end

    // Ones written to the status slot become the clear vector.
    always_comb begin
        clr_vec = (bus_wr && sel_stat) ? bus_wdata : '0;
    end

    // Configuration register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            both_q <= '0;
            en_q   <= '0;
        end else begin
            if (bus_wr && sel_mode)
                mode_q <= bus_wdata;
            if (bus_wr && sel_both)
                both_q <= bus_wdata;
            en_q <= en_nxt;
        end
    end

    // Read mux; aliases and unmapped slots return zero.
    always_comb begin
        bus_rdata = '0;
        if (sel_mode)
            bus_rdata = mode_q;
        else if (sel_both)
            bus_rdata = both_q;
        else if (sel_en)
            bus_rdata = en_q;
        else if (sel_stat)
            bus_rdata = stat_q;
    end

endmodule

// File: rtl/evt_trigger.sv
// Module: evt_trigger
// Registers the previous input word and produces one trigger pulse per pin
// according to that pin's mode (high level, rising edge, any change).
// Assumes: in_word is synchronous to clk.
module evt_trigger
    import gpio_evt_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] in_word,
    input  logic [PINS-1:0] mode_q,
    input  logic [PINS-1:0] both_q,
    output logic [PINS-1:0] prev_q,
    output logic [PINS-1:0] hit
);

    // Edge reference; loaded from the input during reset so no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= in_word;
        else
            prev_q <= in_word;
    end

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        logic changed;

        // Per-pin trigger selection.
        always_comb begin
            changed = in_word[p] ^ prev_q[p];
            unique case (pick_trig(mode_q[p], both_q[p]))
                TRIG_LEVEL: hit[p] = in_word[p];
                TRIG_ANY:   hit[p] = changed;
                TRIG_RISE:  hit[p] = changed & in_word[p];
                default:    hit[p] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/evt_status.sv
// Module: evt_status
// Sticky status register with write-one-to-clear, where a trigger in the
// same cycle overrides the clear, plus the registered interrupt output.
// Assumes: en_nxt is the enable value being loaded on this same edge.
module evt_status #(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] hit,
    input  logic [PINS-1:0] clr_vec,
    input  logic [PINS-1:0] en_nxt,
    output logic [PINS-1:0] stat_q,
    output logic            irq
);

    logic [PINS-1:0] stat_d;

    // Clear first, then OR in triggers so a same-cycle trigger wins.
    always_comb begin
        stat_d = (stat_q & ~clr_vec) | hit;
    end

    // Status and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            irq    <= 1'b0;
        end else begin
            stat_q <= stat_d;
            irq    <= |(stat_d & en_nxt);
        end
    end

endmodule

// File: rtl/gpio_evt_irq.sv
// Module: gpio_evt_irq (top)
// Per-pin event latch and level interrupt for a word of GPIO inputs.
// Assumes: in_word is already polarity-adjusted and synchronous to clk.
module gpio_evt_irq #(
    parameter int unsigned PINS   = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   in_word,
    output logic              irq
);

    logic [PINS-1:0] mode_q, both_q, en_q, en_nxt, clr_vec;
    logic [PINS-1:0] stat_q, prev_q, hit;

    evt_cfg_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .stat_q    (stat_q),
        .mode_q    (mode_q),
        .both_q    (both_q),
        .en_q      (en_q),
        .en_nxt    (en_nxt),
        .clr_vec   (clr_vec),
        .bus_rdata (bus_rdata)
    );

    evt_trigger #(.PINS(PINS)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_word (in_word),
        .mode_q  (mode_q),
        .both_q  (both_q),
        .prev_q  (prev_q),
        .hit     (hit)
    );

    evt_status #(.PINS(PINS)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clr_vec (clr_vec),
        .en_nxt  (en_nxt),
        .stat_q  (stat_q),
        .irq     (irq)
    );

endmodule

// File: rtl/gpio_evt_chk.sv
// Module: gpio_evt_chk
// Property checker bound into gpio_evt_irq.
module gpio_evt_chk #(
    parameter int unsigned PINS   = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   in_word,
    input logic              irq,
    input logic [PINS-1:0]   mode_q,
    input logic [PINS-1:0]   both_q,
    input logic [PINS-1:0]   en_q,
    input logic [PINS-1:0]   stat_q,
    input logic [PINS-1:0]   prev_q,
    input logic [PINS-1:0]   clr_vec,
    input logic [PINS-1:0]   hit
);

    localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(12);

    p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |(stat_q & en_q)));

    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat_q) & ~$past(clr_vec) & ~stat_q) == '0));

    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));

    p_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(in_word & ~mode_q)) == $past(in_word & ~mode_q)));

    p_any_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past((in_word ^ prev_q) & mode_q & both_q))
                  == $past((in_word ^ prev_q) & mode_q & both_q)));

    p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(in_word & ~prev_q & mode_q & ~both_q))
                  == $past(in_word & ~prev_q & mode_q & ~both_q)));

    p_set_alias_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SET_ADDR) |=> (en_q == $past(en_q | bus_wdata)));

endmodule

bind gpio_evt_irq gpio_evt_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .in_word   (in_word),
    .irq       (irq),
    .mode_q    (mode_q),
    .both_q    (both_q),
    .en_q      (en_q),
    .stat_q    (stat_q),
    .prev_q    (prev_q),
    .clr_vec   (clr_vec),
    .hit       (hit)
);

// File: tb/gpio_evt_irq_tb.sv
module gpio_evt_irq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PINS       = 32;
    localparam int ADDR_W     = 8;
    localparam int MAX_CYCLES = 5000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [PINS-1:0]   bus_wdata = '0;
    logic [PINS-1:0]   bus_rdata;
    logic [PINS-1:0]   in_word = '0;
    logic              irq;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    // Behavioural reference state.
    logic [PINS-1:0] m_mode = '0, m_both = '0, m_en = '0, m_stat = '0, m_prev = '0;
    logic            m_irq = 1'b0;

    gpio_evt_irq #(.PINS(PINS), .ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .in_word   (in_word),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [PINS-1:0] model_read(input logic [ADDR_W-1:0] a);
        case (a)
            8'h00:   return m_mode;
            8'h04:   return m_both;
            8'h08:   return m_en;
            8'h14:   return m_stat;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, predict, then compare just after posedge.
    task automatic cycle(input bit rst, input bit wr, input logic [ADDR_W-1:0] a,
                         input logic [PINS-1:0] wd, input logic [PINS-1:0] inw,
                         input string req);
        logic [PINS-1:0] hitv, clrv, ns, nen, nmode, nboth, chg;
        @(negedge clk);
        rst_n = ~rst; bus_wr = wr; bus_addr = a; bus_wdata = wd; in_word = inw;
        if (rst) begin
            nmode = '0; nboth = '0; nen = '0; ns = '0;
        end else begin
            chg  = inw ^ m_prev;
            hitv = (inw & ~m_mode) | (chg & m_mode & m_both) | (chg & inw & m_mode & ~m_both);
            clrv = (wr && a == 8'h14) ? wd : '0;
            ns   = (m_stat & ~clrv) | hitv;
            nmode = (wr && a == 8'h00) ? wd : m_mode;
            nboth = (wr && a == 8'h04) ? wd : m_both;
            nen   = m_en;
            if (wr && a == 8'h08) nen = wd;
            if (wr && a == 8'h0C) nen = m_en | wd;
            if (wr && a == 8'h10) nen = m_en & ~wd;
        end
        @(posedge clk);
        #1;
        m_mode = nmode; m_both = nboth; m_en = nen; m_stat = ns; m_prev = inw;
        m_irq  = rst ? 1'b0 : |(ns & nen);
        check(req, "irq", {{(PINS-1){1'b0}}, irq}, {{(PINS-1){1'b0}}, m_irq});
        check(req, "rdata", bus_rdata, model_read(a));
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        while (!done && cycles < MAX_CYCLES) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, MAX_CYCLES);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [PINS-1:0] lfsr;
        logic [PINS-1:0] inw;
        // R1: reset, with inputs high so no false edge at release.
        cycle(1, 0, 8'h00, '0, 32'h0000_0000, "R1");
        cycle(1, 0, 8'h00, '0, 32'h0000_0030, "R1");
        cycle(1, 0, 8'h04, '0, 32'h0000_0030, "R1");
        // First active cycle: reads must be zero; pin 4/5 edge regs still 0 mode.
        cycle(0, 0, 8'h08, '0, 32'h0000_0000, "R1");
        cycle(0, 0, 8'h14, '0, 32'h0000_0000, "R1");
        // R10: map; R11: mode write takes effect next edge.
        cycle(0, 1, 8'h00, 32'h0000_00F0, 32'h0, "R10");
        cycle(0, 1, 8'h04, 32'h0000_00C0, 32'h0, "R10");
        cycle(0, 1, 8'h0C, 32'h0000_00FF, 32'h0, "R8");
        cycle(0, 0, 8'h0C, '0, 32'h0, "R8");
        cycle(0, 0, 8'h18, '0, 32'h0, "R10");
        cycle(0, 1, 8'h18, 32'hFFFF_FFFF, 32'h0, "R10");
        cycle(0, 0, 8'h01, '0, 32'h0, "R10");
        cycle(0, 0, 8'h00, '0, 32'h0, "R10");
        // R2: level pin 0 high.
        cycle(0, 0, 8'h14, '0, 32'h0000_0001, "R2");
        // R7: clear while pin 0 still high -> stays set.
        cycle(0, 1, 8'h14, 32'h0000_0001, 32'h0000_0001, "R7");
        cycle(0, 0, 8'h14, '0, 32'h0000_0000, "R7");
        // R5: writing zero leaves status.
        cycle(0, 1, 8'h14, 32'h0000_0000, 32'h0000_0000, "R5");
        // R6: clear with input low.
        cycle(0, 1, 8'h14, 32'h0000_0001, 32'h0000_0000, "R6");
        cycle(0, 0, 8'h14, '0, 32'h0000_0000, "R6");
        // R4: rising on pin 4 sets, falling does not.
        cycle(0, 0, 8'h14, '0, 32'h0000_0010, "R4");
        cycle(0, 1, 8'h14, 32'h0000_0010, 32'h0000_0010, "R4");
        cycle(0, 0, 8'h14, '0, 32'h0000_0000, "R4");
        cycle(0, 0, 8'h14, '0, 32'h0000_0000, "R4");
        // R3: any-edge on pin 6 both ways.
        cycle(0, 0, 8'h14, '0, 32'h0000_0040, "R3");
        cycle(0, 1, 8'h14, 32'h0000_0040, 32'h0000_0040, "R3");
        cycle(0, 0, 8'h14, '0, 32'h0000_0000, "R3");
        // R7: clear on the same clock as an edge on pin 7.
        cycle(0, 1, 8'h14, 32'h0000_00C0, 32'h0000_0080, "R7");
        cycle(0, 0, 8'h14, '0, 32'h0000_0080, "R7");
        // R8/R9: clear alias drops interrupt.
        cycle(0, 1, 8'h10, 32'h0000_00FF, 32'h0000_0080, "R9");
        cycle(0, 0, 8'h08, '0, 32'h0000_0080, "R8");
        cycle(0, 1, 8'h0C, 32'h0000_0080, 32'h0000_0080, "R9");
        // R11: switch pin 8 from level to rising while high.
        cycle(0, 0, 8'h14, '0, 32'h0000_0100, "R11");
        cycle(0, 1, 8'h00, 32'h0000_01F0, 32'h0000_0100, "R11");
        cycle(0, 1, 8'h14, 32'hFFFF_FFFF, 32'h0000_0100, "R11");
        cycle(0, 0, 8'h14, '0, 32'h0000_0100, "R11");
        // Mixed pseudo-random phase.
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            inw  = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            case (lfsr[2:0])
                3'd0: cycle(0, 1, 8'h14, lfsr, inw, "R7");
                3'd1: cycle(0, 1, 8'h0C, lfsr & 32'h0F0F_0F0F, inw, "R8");
                3'd2: cycle(0, 1, 8'h10, lfsr, inw, "R8");
                3'd3: cycle(0, 1, 8'h00, lfsr | 32'hFFFF_0000, inw, "R11");
                3'd4: cycle(0, 1, 8'h04, lfsr, inw, "R3");
                3'd5: cycle(0, 0, 8'h08, '0, inw, "R9");
                default: cycle(0, 0, 8'h14, '0, inw, "R5");
            endcase
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule